// File: doc/BRIEF.md
# EEPROM Page Writer with Acknowledge Polling

This block performs a complete write into a two-wire serial EEPROM. A single request gives the 7-bit device identifier, a 16-bit memory start address and a byte count. The payload arrives as a valid/ready byte stream. The block cuts the request into bus transactions so that none of them runs past a 32-byte page edge. Each transaction carries the device identifier with the write direction bit, then the memory address high byte, then the memory address low byte, then the data bytes. A STOP condition closes the transaction. The memory then starts its internal programming cycle.

While the memory is programming, it does not acknowledge its identifier. The block treats an unacknowledged identifier byte as "still busy" and tries again. Each try is a START, the identifier byte and a STOP, repeated until the memory acknowledges. The next transaction, or the final completion, continues from the START that was acknowledged. A missing acknowledge on a memory address byte or on a data byte is a hard failure. So is a run of too many busy replies in a row. Both end the request with an error pulse.

The bus pins are modelled as open-drain enables. A bit engine produces each SCL period in four quarters from a parameterized clock divider. Only START and STOP move SDA while SCL is high. The stream has back-pressure: `wdata_ready` is high only while the engine is idle and the next action is to shift out a payload byte. If `wdata_valid` is low at that point, SCL is held low until a byte arrives. The source must keep `wdata_valid` high and `wdata` stable until the byte is accepted on a clock edge where both signals are high.

Top module: `eew_page_writer`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `wdata_ready` are low and both SCL and SDA are released. Whenever `busy` is low, both bus lines are released.
- R2: Each write transaction sends, in this order: START, the byte {identifier, 0}, the address high byte, the address low byte, the data bytes and STOP. Byte bits are sent most significant first. The payload lands at consecutive addresses starting at the requested one.
- R3: No transaction crosses a 32-byte page edge, meaning addresses whose low 5 bits are zero. The first transaction carries min(32 − addr[4:0], count) bytes. A request spanning N pages uses exactly N transactions.
- R4: After every STOP that ends a data transaction, and before the first one, the block repeats START, identifier byte and STOP until the identifier is acknowledged. Only then does it continue or finish. `done` therefore marks a finished internal programming cycle. A count of zero only performs this poll.
- R5: When MAX_TRIES identifier bytes in a row are not acknowledged, the block issues STOP, pulses `error`, consumes no further payload and returns to idle.
- R6: A missing acknowledge on an address byte or a data byte ends the request at once. The block sends STOP, pulses `error`, and accepts no further payload bytes.
- R7: `wdata_ready` is high only while a payload byte is about to be shifted out. Exactly `byte_count` bytes are consumed by a request that completes, whatever gaps the source leaves in `wdata_valid`.
- R8: `req` is taken only while `busy` is low. A `req` pulse during a busy request has no effect on the bus or memory.
- R9: SDA changes only while SCL is low, except for START (SDA falls with SCL high) and STOP (SDA rises with SCL high). At each SCL edge the SDA drive is unchanged.
- R10: `done` and `error` are single-cycle pulses, never high together. `busy` is low in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a write request (taken when `busy` is low) |
| dev_addr | input | 7 | Device identifier on the bus |
| mem_addr | input | 16 | First memory address to write |
| byte_count | input | CNT_W | Number of payload bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: request completed and committed |
| error | output | 1 | One-cycle pulse: request aborted |
| wdata | input | 8 | Payload byte |
| wdata_valid | input | 1 | Payload byte present |
| wdata_ready | output | 1 | Block takes the payload byte on this edge |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bench builds the block with QTR_CYC=2, MAX_TRIES=5 and CNT_W=8. The short quarter makes multi-page requests of up to about 70 bytes cheap, so page splitting, partial first pages and several busy polls per transaction all fit in a short run. The small try limit makes a memory that stays busy reach the retry error within a few polls. The limit can then be checked exactly against the number of refused identifier bytes a bus-level memory model counts.

// File: rtl/eew_pkg.sv
package eew_pkg;
  // operation requested from the bit engine
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_BYTE  = 2'd2
  } bus_op_e;

  // sequencer states
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_DEV,
    SQ_AHI,
    SQ_ALO,
    SQ_DATA,
    SQ_STOP
  } seq_st_e;

  // what to do once the pending STOP has gone out
  typedef enum logic [1:0] {
    AF_RESTART,
    AF_DONE,
    AF_FAIL
  } after_stop_e;
endpackage

// File: rtl/eew_bit_engine.sv
module eew_bit_engine
  import eew_pkg::*;
#(
  parameter int QTR_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  output logic       cmd_ready,
  output logic       op_done,
  output logic       op_nack,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  logic          busy_q, done_q, nack_q;
  bus_op_e       op_q;
  logic [7:0]    sh_q;
  logic [3:0]    bit_q;
  logic [1:0]    qtr_q;
  logic [CW-1:0] div_q;
  logic          scl_q, sda_q;
  logic          tick, bit_val, scl_lo, sda_lo;

  assign tick = busy_q && (div_q == CW'(QTR_CYC - 1));

  // line levels for the current quarter of the current operation
  always_comb begin
    bit_val = bit_q[3] ? 1'b1 : sh_q[7];
    unique case (op_q)
      OP_START: begin
        scl_lo = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_lo = qtr_q[1];
      end
      OP_STOP: begin
        scl_lo = (qtr_q == 2'd0);
        sda_lo = !qtr_q[1];
      end
      default: begin
        scl_lo = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_lo = !bit_val;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
      op_q   <= OP_STOP;
      sh_q   <= '0;
      bit_q  <= '0;
      qtr_q  <= '0;
      div_q  <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q <= 1'b1;
          op_q   <= cmd_op;
          sh_q   <= cmd_byte;
          bit_q  <= '0;
          qtr_q  <= '0;
          div_q  <= '0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (op_q == OP_BYTE && bit_q == 4'd8 && qtr_q == 2'd2)
            nack_q <= sda_in;
          if (qtr_q == 2'd3) begin
            if (op_q == OP_BYTE && bit_q != 4'd8) begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[6:0], 1'b0};
              qtr_q <= '0;
            end else begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end else begin
            qtr_q <= qtr_q + 1'b1;
          end
        end
      end
      if (busy_q) begin
        scl_q <= scl_lo;
        sda_q <= sda_lo;
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign op_done   = done_q;
  assign op_nack   = nack_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
endmodule

// File: rtl/eew_write_seq.sv
module eew_write_seq
  import eew_pkg::*;
#(
  parameter int MAX_TRIES  = 16,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [6:0]       dev_addr,
  input  logic [15:0]      mem_addr,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  output logic             error,
  input  logic [7:0]       wdata,
  input  logic             wdata_valid,
  output logic             wdata_ready,
  output logic             cmd_valid,
  output bus_op_e          cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_ready,
  input  logic             op_done,
  input  logic             op_nack
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int XW = (CNT_W > PW + 1) ? CNT_W : PW + 1;
  localparam int TW = $clog2(MAX_TRIES + 1);

  seq_st_e          st_q;
  after_stop_e      after_q;
  logic             sent_q, done_q, err_q;
  logic [6:0]       dev_q;
  logic [15:0]      addr_q;
  logic [CNT_W-1:0] rem_q;
  logic [XW-1:0]    chunk_q, chunk_n, room_x, rem_x;
  logic [TW-1:0]    tries_q;
  logic             fire;

  // bytes left before the page edge, capped by what remains
  assign room_x  = XW'(PAGE_BYTES) - XW'(addr_q[PW-1:0]);
  assign rem_x   = XW'(rem_q);
  assign chunk_n = (rem_x < room_x) ? rem_x : room_x;

  always_comb begin
    cmd_op   = OP_BYTE;
    cmd_byte = 8'h00;
    unique case (st_q)
      SQ_START: cmd_op = OP_START;
      SQ_STOP:  cmd_op = OP_STOP;
      SQ_DEV:   cmd_byte = {dev_q, 1'b0};
      SQ_AHI:   cmd_byte = addr_q[15:8];
      SQ_ALO:   cmd_byte = addr_q[7:0];
      SQ_DATA:  cmd_byte = wdata;
      default:  cmd_op = OP_BYTE;
    endcase
  end

  assign cmd_valid   = (st_q != SQ_IDLE) && !sent_q && (st_q != SQ_DATA || wdata_valid);
  assign wdata_ready = (st_q == SQ_DATA) && !sent_q && cmd_ready;
  assign fire        = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      after_q <= AF_RESTART;
      sent_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      dev_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      tries_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (fire) sent_q <= 1'b1;
      if (st_q == SQ_IDLE) begin
        if (req) begin
          dev_q   <= dev_addr;
          addr_q  <= mem_addr;
          rem_q   <= byte_count;
          tries_q <= '0;
          sent_q  <= 1'b0;
          st_q    <= SQ_START;
        end
      end else if (op_done) begin
        sent_q <= 1'b0;
        unique case (st_q)
          SQ_START: st_q <= SQ_DEV;
          SQ_DEV: begin
            if (op_nack) begin
              tries_q <= tries_q + 1'b1;
              after_q <= (tries_q == TW'(MAX_TRIES - 1)) ? AF_FAIL : AF_RESTART;
              st_q    <= SQ_STOP;
            end else begin
              tries_q <= '0;
              if (rem_q == '0) begin
                after_q <= AF_DONE;
                st_q    <= SQ_STOP;
              end else begin
                chunk_q <= chunk_n;
                st_q    <= SQ_AHI;
              end
            end
          end
          SQ_AHI, SQ_ALO: begin
            if (op_nack) begin
              after_q <= AF_FAIL;
              st_q    <= SQ_STOP;
            end else begin
              st_q <= (st_q == SQ_AHI) ? SQ_ALO : SQ_DATA;
            end
          end
          SQ_DATA: begin
            if (op_nack) begin
              after_q <= AF_FAIL;
              st_q    <= SQ_STOP;
            end else begin
              addr_q  <= addr_q + 1'b1;
              rem_q   <= rem_q - 1'b1;
              chunk_q <= chunk_q - 1'b1;
              if (chunk_q == XW'(1)) begin
                after_q <= AF_RESTART;
                st_q    <= SQ_STOP;
              end
            end
          end
          SQ_STOP: begin
            unique case (after_q)
              AF_RESTART: st_q <= SQ_START;
              AF_DONE: begin
                done_q <= 1'b1;
                st_q   <= SQ_IDLE;
              end
              default: begin
                err_q <= 1'b1;
                st_q  <= SQ_IDLE;
              end
            endcase
          end
          default: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign busy  = (st_q != SQ_IDLE);
  assign done  = done_q;
  assign error = err_q;
endmodule

// File: rtl/eew_page_writer.sv
module eew_page_writer
  import eew_pkg::*;
#(
  parameter int QTR_CYC    = 4,
  parameter int MAX_TRIES  = 16,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [6:0]       dev_addr,
  input  logic [15:0]      mem_addr,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  output logic             error,
  input  logic [7:0]       wdata,
  input  logic             wdata_valid,
  output logic             wdata_ready,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic       cmd_valid, cmd_ready, op_done, op_nack;
  bus_op_e    cmd_op;
  logic [7:0] cmd_byte;

  eew_write_seq #(
    .MAX_TRIES (MAX_TRIES),
    .CNT_W     (CNT_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .dev_addr   (dev_addr),
    .mem_addr   (mem_addr),
    .byte_count (byte_count),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .wdata      (wdata),
    .wdata_valid(wdata_valid),
    .wdata_ready(wdata_ready),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_byte   (cmd_byte),
    .cmd_ready  (cmd_ready),
    .op_done    (op_done),
    .op_nack    (op_nack)
  );

  eew_bit_engine #(
    .QTR_CYC(QTR_CYC)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_byte (cmd_byte),
    .cmd_ready(cmd_ready),
    .op_done  (op_done),
    .op_nack  (op_nack),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .sda_in   (sda_in)
  );
endmodule

// File: rtl/eew_page_writer_chk.sv
module eew_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic done,
  input logic error,
  input logic wdata_ready,
  input logic scl_oe,
  input logic sda_oe
);
  assert_idle_bus_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_ready_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_ready |-> busy);

  assert_req_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);

  assert_sda_still_at_scl_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe) || $fell(scl_oe)) |-> $stable(sda_oe));

  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  assert_error_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (!busy && !error));
endmodule

bind eew_page_writer eew_page_writer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .wdata_ready(wdata_ready),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe)
);

// File: tb/eew_page_writer_tb.sv
module eew_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR       = 2;
  localparam int TRIES     = 5;
  localparam int CW        = 8;
  localparam logic [6:0] DEV_ID = 7'h50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [6:0]    dev_addr = DEV_ID;
  logic [15:0]   mem_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          busy, done, error, wdata_ready, scl_oe, sda_oe;
  logic [7:0]    wdata = '0;
  logic          wdata_valid = 1'b0;
  logic          sda_in;
  logic          slv_pull = 1'b0;
  logic          scl_w, sda_w;

  assign scl_w  = ~scl_oe;
  assign sda_w  = ~(sda_oe | slv_pull);
  assign sda_in = sda_w;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eew_page_writer #(.QTR_CYC(QTR), .MAX_TRIES(TRIES), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_addr(dev_addr), .mem_addr(mem_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .error(error),
    .wdata(wdata), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- bus-level memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] shreg = '0;
  logic [7:0] ahi = '0;
  logic [15:0] ptr = '0;
  int  bitcnt = 0, byte_idx = 0, txn_len = 0;
  bit  in_frame = 0;
  int  busy_left = 0, busy_cfg = 0, polls_seen = 0, txn_cnt = 0, first_len = 0;
  int  violations = 0, glitches = 0, data_seen = 0, data_nack_at = 0;
  bit  nack_ahi = 0;

  task automatic take_byte(output bit ack);
    int off;
    ack = 1'b1;
    if (byte_idx == 0) begin
      if (shreg[7:1] == DEV_ID && !shreg[0]) begin
        if (busy_left > 0) begin
          busy_left--;
          polls_seen++;
          ack = 1'b0;
        end
      end else ack = 1'b0;
    end else if (byte_idx == 1) begin
      ahi = shreg;
      ack = !nack_ahi;
    end else if (byte_idx == 2) begin
      ptr = {ahi, shreg};
    end else begin
      off = int'(ptr[4:0]) + txn_len;
      if (off >= 32) violations++;
      mem[int'({ptr[15:5], 5'(off)})] = shreg;
      txn_len++;
      data_seen++;
      if (data_nack_at != 0 && data_seen == data_nack_at) ack = 1'b0;
    end
  endtask

  always @(negedge sda_w) if (scl_w) begin
    if (bitcnt >= 2 && bitcnt <= 8) glitches++;
    in_frame = 1; bitcnt = 0; byte_idx = 0; txn_len = 0;
  end

  always @(posedge sda_w) if (scl_w) begin
    if (bitcnt >= 2 && bitcnt <= 8) glitches++;
    if (in_frame && byte_idx >= 3 && txn_len > 0) begin
      txn_cnt++;
      if (txn_cnt == 1) first_len = txn_len;
      busy_left = busy_cfg;
    end
    in_frame = 0; bitcnt = 0; slv_pull = 1'b0;
  end

  always @(posedge scl_w) if (in_frame && bitcnt < 8) begin
    shreg = {shreg[6:0], sda_w};
    bitcnt++;
  end

  always @(negedge scl_w) if (in_frame) begin
    bit a;
    if (bitcnt == 8) begin
      take_byte(a);
      slv_pull = a;
      bitcnt = 9;
      byte_idx++;
    end else if (bitcnt == 9) begin
      slv_pull = 1'b0;
      bitcnt = 0;
    end
  end

  // ---------------- payload source with random gaps ----------------
  logic [7:0] src [$];
  bit hs_pend = 0;
  int consumed = 0;

  always @(negedge clk) begin
    bit keep;
    keep = wdata_valid && !hs_pend && (src.size() > 0);
    if (hs_pend) begin
      void'(src.pop_front());
      consumed++;
    end
    if (src.size() > 0 && (keep || ($urandom % 4) != 0)) begin
      wdata_valid <= 1'b1;
      wdata       <= src[0];
    end else begin
      wdata_valid <= 1'b0;
    end
    hs_pend = (src.size() > 0) && (keep || wdata_valid) && wdata_ready;
  end

  // ---------------- helpers ----------------
  function automatic int pages(input int a, input int n);
    if (n == 0) return 0;
    return ((a % 32) + n - 1) / 32 + 1;
  endfunction

  function automatic int first_chunk(input int a, input int n);
    int room = 32 - (a % 32);
    return (n < room) ? n : room;
  endfunction

  bit got_d, got_e;
  logic [7:0] exp_data [$];

  task automatic run_req(input int a, input int n, input int bcfg, input int preset, input bit stray);
    int cyc;
    got_d = 0; got_e = 0;
    txn_cnt = 0; polls_seen = 0; first_len = 0; violations = 0; glitches = 0;
    data_seen = 0; consumed = 0;
    busy_cfg = bcfg; busy_left = preset;
    exp_data.delete();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      exp_data.push_back(b);
      src.push_back(b);
    end
    @(negedge clk);
    mem_addr = 16'(a); byte_count = CW'(n); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!(got_d || got_e) && cyc < 60000) begin
      @(negedge clk);
      if (stray && cyc == 300) begin
        mem_addr = 16'(a) ^ 16'h8000; req = 1'b1;
      end else req = 1'b0;
      if (done) got_d = 1;
      if (error) got_e = 1;
      cyc++;
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_ok(input int a, input int n, input int bcfg, input string tag);
    int bad = 0;
    chk(got_d && !got_e, {tag, " R10 done pulse"}, got_d, 1);
    chk(!done && !busy, {tag, " R10 pulse single and idle after"}, done, 0);
    for (int i = 0; i < n; i++) begin
      int k = (a + i) & 16'hFFFF;
      if (!mem.exists(k) || mem[k] !== exp_data[i]) bad++;
    end
    chk(bad == 0, {tag, " R2 memory content"}, bad, 0);
    chk(txn_cnt == pages(a, n) && violations == 0, {tag, " R3 page split"}, txn_cnt, pages(a, n));
    if (n > 0) chk(first_len == first_chunk(a, n), {tag, " R3 first length"}, first_len, first_chunk(a, n));
    chk(polls_seen == txn_cnt * bcfg, {tag, " R4 busy polls"}, polls_seen, txn_cnt * bcfg);
    chk(consumed == n, {tag, " R7 bytes consumed"}, consumed, n);
    chk(glitches == 0, {tag, " R9 sda with scl high"}, glitches, 0);
    chk(!scl_oe && !sda_oe, {tag, " R1 bus released after"}, {scl_oe, sda_oe}, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(!busy && !done && !error && !wdata_ready, "R1 reset outputs", {busy, done, error, wdata_ready}, 0);
    chk(!scl_oe && !sda_oe, "R1 reset bus released", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R1 idle after reset", {busy, scl_oe, sda_oe}, 0);

    // directed corner cases
    run_req(16'h001F, 2, 1, 0, 0);  check_ok(16'h001F, 2, 1, "cross");
    run_req(16'h0020, 32, 2, 0, 0); check_ok(16'h0020, 32, 2, "fullpage");
    run_req(16'h0FF0, 64, 0, 0, 0); check_ok(16'h0FF0, 64, 0, "threepage");
    run_req(16'h1234, 1, 3, 0, 0);  check_ok(16'h1234, 1, 3, "single");

    // R8: stray request while busy must be ignored
    run_req(16'h0105, 40, 1, 0, 1);
    check_ok(16'h0105, 40, 1, "R8 stray");
    chk(!mem.exists(32'h8105), "R8 stray req ignored", mem.exists(32'h8105), 0);

    // R4: zero count only polls; preset busy shows polls before done
    run_req(16'h0300, 0, 0, 2, 0);
    chk(got_d && !got_e && polls_seen == 2, "R4 zero count polls", polls_seen, 2);
    chk(consumed == 0 && txn_cnt == 0, "R4 zero count no data", consumed, 0);

    // random requests
    for (int r = 0; r < 6; r++) begin
      int a = int'($urandom % 65536);
      int n = 1 + int'($urandom % 70);
      int bc = int'($urandom % 4);
      run_req(a, n, bc, 0, 0);
      check_ok(a, n, bc, "random");
    end

    // R5: memory that never becomes ready
    run_req(16'h0400, 4, 0, 100, 0);
    chk(got_e && !got_d, "R5 retry limit error", got_e, 1);
    chk(polls_seen == TRIES, "R5 tries used", polls_seen, TRIES);
    chk(consumed == 0 && !busy && !scl_oe && !sda_oe, "R5 idle no payload", consumed, 0);
    src.delete(); busy_left = 0;
    repeat (4) @(negedge clk);

    // R6: address byte refused
    nack_ahi = 1;
    run_req(16'h0500, 5, 0, 0, 0);
    nack_ahi = 0;
    chk(got_e && !got_d, "R6 address nack error", got_e, 1);
    chk(consumed == 0, "R6 address nack no payload", consumed, 0);
    src.delete();
    repeat (4) @(negedge clk);

    // R6: third data byte refused
    data_nack_at = 3;
    run_req(16'h0600, 10, 0, 0, 0);
    data_nack_at = 0;
    chk(got_e && !got_d, "R6 data nack error", got_e, 1);
    chk(consumed == 3, "R6 data nack stops payload", consumed, 3);
    chk(!busy && !scl_oe && !sda_oe, "R6 bus released", {busy, scl_oe, sda_oe}, 0);
    src.delete();
    repeat (4) @(negedge clk);

    // recovery after errors
    run_req(16'h07E0, 33, 1, 0, 0); check_ok(16'h07E0, 33, 1, "recover");

    summary();
  end
endmodule